// File: doc/BRIEF.md
# Add/Subtract Arithmetic Unit with Latched Carry

This block is the arithmetic stage of a small bus-oriented datapath. It takes two operand words from registers outside the block. It forms either their sum or their difference, and the result wraps modulo 2^WIDTH. There is only one adder. For a difference, every bit of the second operand is XOR-inverted and the adder's carry-in is forced to one, which gives two's-complement subtraction. As a result, a subtraction leaves a carry-out of one whenever no borrow occurs.

The result reaches the shared bus only while the sum-out enable is high. At all other times the block drives zeros, so the bus can be OR-combined with other sources. A one-bit carry register keeps the adder's carry-out, but it captures it only on a clock edge where the flag-load strobe is high. The register's next-state choice is a three-way action with these members:

- FLAG_CLEAR: synchronous reset, which has the highest priority.
- FLAG_CAPTURE: the strobe is high.
- FLAG_KEEP: neither of the above.

Transitions happen on every rising clock edge: any action can follow any action, and the choice depends only on the reset and strobe inputs.

Top module: `addsub_alu`

## Requirements
- R1: With sub_sel=0 and sum_oe=1, bus_out equals (opnd_a + opnd_b) mod 256 in the same cycle.
- R2: With sub_sel=1 and sum_oe=1, bus_out equals (opnd_a - opnd_b) mod 256 in the same cycle; for example, 0 - 1 gives 255.
- R3: After a rising edge with flag_ld=1 and rst=0, carry_flag equals the adder carry-out for the inputs present at that edge. For an addition, the carry-out is 1 when opnd_a + opnd_b > 255. For a subtraction, it is 1 when opnd_a >= opnd_b.
- R4: A captured subtraction of 1 gives carry_flag=1 when opnd_a is nonzero, and carry_flag=0 when opnd_a is 0.
- R5: After a rising edge with flag_ld=0 and rst=0, carry_flag keeps its previous value, whatever the operands and the subtract control are.
- R6: After a rising edge with rst=1, carry_flag is 0, even when flag_ld is high and the adder's carry-out is 1.
- R7: While sum_oe=0, bus_out is 0.
- R8: bus_out follows changes of opnd_a, opnd_b and sub_sel without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the carry register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the carry register |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand (the subtrahend when subtracting) |
| sub_sel | input | 1 | 1 selects opnd_a - opnd_b, 0 selects opnd_a + opnd_b |
| sum_oe | input | 1 | Places the result on bus_out |
| flag_ld | input | 1 | Carry capture strobe |
| bus_out | output | 8 | Result when enabled, otherwise zero |
| carry_flag | output | 1 | Registered carry-out |

## Verification
The hardest conditions to reach are at the flag register. One is a capture of subtract-by-one from a zero operand. Another is a held flag while the operands would produce the opposite carry. A third is a reset that coincides with a strobe whose carry-out is 1. Random operands seldom produce B=1 or A=0, and seldom line up the strobe against reset, so directed steps set these combinations up explicitly. A seeded random run, with independent probabilities for strobe, reset, enable and subtract, then mixes capture, hold and clear actions in arbitrary orders.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Next-state action of the carry register
    typedef enum logic [1:0] {
        FLAG_KEEP    = 2'd0,
        FLAG_CAPTURE = 2'd1,
        FLAG_CLEAR   = 2'd2
    } flag_act_e;

    function automatic flag_act_e pick_action(input logic rst, input logic load);
        if (rst)       return FLAG_CLEAR;
        else if (load) return FLAG_CAPTURE;
        else           return FLAG_KEEP;
    endfunction

endpackage

// File: rtl/operand_cond.sv
module operand_cond #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             invert,
    output logic [WIDTH-1:0] b_out,
    output logic             cin
);
    // Per-bit XOR gating: B passes through or is inverted
    for (genvar i = 0; i < WIDTH; i++) begin : g_xor
        assign b_out[i] = b_in[i] ^ invert;
    end
    // Forced carry-in completes the two's complement
    assign cin = invert;
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        logic p;
        assign p           = x[i] ^ y[i];
        assign sum[i]      = p ^ chain[i];
        assign chain[i+1]  = (x[i] & y[i]) | (p & chain[i]);
    end

    assign cout = chain[WIDTH];
endmodule

// File: rtl/carry_flag_reg.sv
module carry_flag_reg
    import alu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic d,
    output logic q
);
    flag_act_e act;
    logic      q_next;

    always_comb begin
        act = pick_action(rst, load);
    end

    always_comb begin
        unique case (act)
            FLAG_CLEAR:   q_next = 1'b0;
            FLAG_CAPTURE: q_next = d;
            FLAG_KEEP:    q_next = q;
            default:      q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_next;
    end
endmodule

// File: rtl/bus_gate.sv
module bus_gate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data,
    input  logic             en,
    output logic [WIDTH-1:0] bus
);
    // Zero when idle so that bus sources can be OR-combined
    for (genvar i = 0; i < WIDTH; i++) begin : g_and
        assign bus[i] = data[i] & en;
    end
endmodule

// File: rtl/addsub_alu.sv
module addsub_alu #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             sub_sel,
    input  logic             sum_oe,
    input  logic             flag_ld,
    output logic [WIDTH-1:0] bus_out,
    output logic             carry_flag
);
    logic [WIDTH-1:0] b_cond;
    logic             add_cin;
    logic [WIDTH-1:0] result;
    logic             add_cout;

    operand_cond #(.WIDTH(WIDTH)) u_cond (
        .b_in   (opnd_b),
        .invert (sub_sel),
        .b_out  (b_cond),
        .cin    (add_cin)
    );

    ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x    (opnd_a),
        .y    (b_cond),
        .cin  (add_cin),
        .sum  (result),
        .cout (add_cout)
    );

    carry_flag_reg u_flag (
        .clk  (clk),
        .rst  (rst),
        .load (flag_ld),
        .d    (add_cout),
        .q    (carry_flag)
    );

    bus_gate #(.WIDTH(WIDTH)) u_bus (
        .data (result),
        .en   (sum_oe),
        .bus  (bus_out)
    );
endmodule

// File: rtl/addsub_alu_chk.sv
module addsub_alu_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             sub_sel,
    input logic             sum_oe,
    input logic             flag_ld,
    input logic [WIDTH-1:0] bus_out,
    input logic             carry_flag
);
    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, opnd_a}
                     + {1'b0, (sub_sel ? ~opnd_b : opnd_b)}
                     + {{WIDTH{1'b0}}, sub_sel};

    AST_SUM_ON_BUS: assert property (@(posedge clk) disable iff (rst)
        (sum_oe && !sub_sel) |-> bus_out == WIDTH'(opnd_a + opnd_b)); // R1
    AST_DIFF_ON_BUS: assert property (@(posedge clk) disable iff (rst)
        (sum_oe && sub_sel) |-> bus_out == WIDTH'(opnd_a - opnd_b)); // R2
    AST_CARRY_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        flag_ld |=> carry_flag == $past(ref_total[WIDTH])); // R3
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        (flag_ld && sub_sel && opnd_b == WIDTH'(1)) |=> carry_flag == ($past(opnd_a) != '0)); // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_ld |=> $stable(carry_flag)); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !carry_flag); // R6
    AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !sum_oe |-> bus_out == '0); // R7
endmodule

bind addsub_alu addsub_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .sub_sel    (sub_sel),
    .sum_oe     (sum_oe),
    .flag_ld    (flag_ld),
    .bus_out    (bus_out),
    .carry_flag (carry_flag)
);

// File: tb/addsub_alu_tb_top.sv
module addsub_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] opnd_a = '0;
    logic [7:0] opnd_b = '0;
    logic       sub_sel = 1'b0;
    logic       sum_oe = 1'b0;
    logic       flag_ld = 1'b0;
    logic [7:0] bus_out;
    logic       carry_flag;

    int    n_checks = 0;
    int    n_fail = 0;
    logic  model_flag = 1'b0;
    logic  have_prev = 1'b0;
    string flag_tag = "R6";

    always #5 clk = ~clk;

    addsub_alu dut_i (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .sub_sel(sub_sel), .sum_oe(sum_oe), .flag_ld(flag_ld),
        .bus_out(bus_out), .carry_flag(carry_flag)
    );

    function automatic logic [7:0] exp_result(logic [7:0] a, logic [7:0] b, logic s);
        return s ? 8'(a - b) : 8'(a + b);
    endfunction

    function automatic logic exp_carry(logic [7:0] a, logic [7:0] b, logic s);
        if (s) return (a >= b);
        return ((9'(a) + 9'(b)) > 9'd255);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(logic [7:0] a, logic [7:0] b, logic s, logic oe, logic ld, logic r);
        @(negedge clk);
        if (have_prev) chk(flag_tag, {7'd0, carry_flag}, {7'd0, model_flag});
        opnd_a = a; opnd_b = b; sub_sel = s; sum_oe = oe; flag_ld = ld; rst = r;
        #1;
        chk(!oe ? "R7" : (s ? "R2" : "R1"), bus_out, oe ? exp_result(a, b, s) : 8'd0);
        @(posedge clk);
        have_prev = 1'b1;
        if (r) begin
            model_flag = 1'b0; flag_tag = "R6";
        end else if (ld) begin
            model_flag = exp_carry(a, b, s);
            flag_tag = (s && b == 8'd1) ? "R4" : "R3";
        end else begin
            flag_tag = "R5";
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        // reset state: flag cleared, bus idle
        step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        // R3 add with carry, wrap to zero
        step(8'd200, 8'd100, 1'b0, 1'b1, 1'b1, 1'b0);
        step(8'd255, 8'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(8'd10, 8'd20, 1'b0, 1'b1, 1'b1, 1'b0);
        // R4 decrement by one, nonzero and zero
        step(8'd5, 8'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        step(8'd0, 8'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        step(8'd1, 8'd1, 1'b1, 1'b1, 1'b1, 1'b0);
        // R3 subtract equal operands gives carry 1, smaller-minus-larger gives 0
        step(8'd77, 8'd77, 1'b1, 1'b1, 1'b1, 1'b0);
        step(8'd3, 8'd90, 1'b1, 1'b1, 1'b1, 1'b0);
        // R5 hold while carry-out would be 1
        step(8'd255, 8'd255, 1'b0, 1'b0, 1'b0, 1'b0);
        step(8'd9, 8'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R6 reset wins over strobe with carry-out 1
        step(8'd250, 8'd250, 1'b0, 1'b1, 1'b1, 1'b0);
        step(8'd250, 8'd250, 1'b0, 1'b1, 1'b1, 1'b1);
        step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R8 bus follows inputs with no clock edge in between
        @(negedge clk);
        sum_oe = 1'b1; opnd_a = 8'd40; opnd_b = 8'd2; sub_sel = 1'b0;
        #1 chk("R8", bus_out, 8'd42);
        opnd_a = 8'd41; #1 chk("R8", bus_out, 8'd43);
        sub_sel = 1'b1; #1 chk("R8", bus_out, 8'd39);
        // seeded random mix
        for (int i = 0; i < 400; i++) begin
            step(8'($urandom), 8'($urandom), 1'($urandom),
                 ($urandom % 4) != 0, 1'($urandom), ($urandom % 20) == 0);
        end
        step(8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule